// File: doc/BRIEF.md
# Three-Way Pin Multiplexer and GPIO Bank

This block controls one bank of 32 I/O pads. For each pad it decides who drives it. The choices are the general-purpose I/O logic, internal peripheral A or internal peripheral B. In GPIO mode it supplies the output value and the output enable. It also supplies a pull-up request for each pad and can switch each pad to open-drain operation, where the pad only pulls low.

Software reaches the block over a simple single-cycle register bus. Every per-pin control vector has three addresses: a set address, a clear address and a status address. A write to the set address turns on only the pins whose mask bit is 1. A write to the clear address turns off only those pins. Zero mask bits leave their pins alone, so software never needs a read-modify-write. The pad input levels pass through a two-stage synchronizer. The synchronized levels can be read back for every pin, whatever its mux setting, and they are also handed to the peripherals.

Top module: `pinmux_bank`

## Requirements
- R1: After reset, the status of each control vector reads as follows. GPIO-enable and pull-up are all ones. Peripheral-B select, output enable, output data and open-drain are all zeros. `bus_rdata` is zero.
- R2: The address layout is fixed. `bus_addr[4:2]` picks the control vector: 0 GPIO-enable, 1 peripheral-B select, 2 output enable, 3 output data, 4 pull-up, 5 open-drain. `bus_addr[1:0]` picks the action: 0 set, 1 clear, 2 status. A write to a set address turns on exactly the pins whose `bus_wdata` bit is 1, from the next clock edge onward. All other pins keep their value.
- R3: A write to a clear address turns off exactly the pins whose `bus_wdata` bit is 1, from the next clock edge onward. All other pins keep their value.
- R4: A read (`bus_sel`=1, `bus_wr`=0) of a status address returns that vector on `bus_rdata` one cycle later. A read of any other address returns zero, except address 0x1A (see R9). When there is no read, `bus_rdata` is zero on the next cycle. A write to a status address or to an unmapped address changes no state.
- R5: A pin with GPIO-enable=1 and open-drain=0 drives `pad_out` from its output data bit and `pad_oe` from its output enable bit.
- R6: A pin with GPIO-enable=0 takes `pad_out`/`pad_oe` from peripheral A (`pa_out`/`pa_oe`) when its select bit is 0, and from peripheral B (`pb_out`/`pb_oe`) when its select bit is 1.
- R7: With open-drain=1, a pin's `pad_out` is always 0. Its `pad_oe` is high only when the chosen source enables its output and wants a low level. A high level therefore releases the pad.
- R8: `pad_pu` equals the pull-up vector at all times.
- R9: `periph_in` shows `pad_in` two clock edges later. A read of address 0x1A returns these synchronized levels for all pins, including pins muxed to a peripheral.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pu | output | 32 | Pad pull-up enable |
| pa_out | input | 32 | Peripheral A output value |
| pa_oe | input | 32 | Peripheral A output enable |
| pb_out | input | 32 | Peripheral B output value |
| pb_oe | input | 32 | Peripheral B output enable |
| periph_in | output | 32 | Synchronized pad levels for the peripherals |

## Verification
The assertions check several rules on every cycle:
- the mask semantics of the output-enable set and output-data clear addresses;
- the one-cycle read latency and the idle-zero read data;
- the two-edge synchronizer delay;
- the rule that an open-drain pad never drives high;
- the stability of the pull-up outputs when no pull-up write occurs;
- the reset values.

Other behaviour shows up only in the bench scenarios:
- the full three-way mux selection;
- writes to status or unmapped addresses being ignored;
- the pin-level read of peripheral-owned pins;
- mixed random traffic across all six vectors checked against a reference model.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int NPIN   = 32;
    localparam int ADDR_W = 5;
    localparam int NCTL   = 6;
    localparam int IDX_W  = 3;

    typedef enum logic [IDX_W-1:0] {
        CTL_GPIO  = 3'd0,
        CTL_SELB  = 3'd1,
        CTL_OE    = 3'd2,
        CTL_DOUT  = 3'd3,
        CTL_PU    = 3'd4,
        CTL_OD    = 3'd5,
        CTL_LEVEL = 3'd6,
        CTL_NONE  = 3'd7
    } ctl_idx_e;

    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_CLR  = 2'd1,
        OP_STAT = 2'd2,
        OP_RSVD = 2'd3
    } ctl_op_e;

    typedef struct packed {
        ctl_idx_e idx;
        ctl_op_e  op;
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d.idx = ctl_idx_e'(a[4:2]);
        d.op  = ctl_op_e'(a[1:0]);
        return d;
    endfunction

    // GPIO-enable and pull-up come out of reset set; the rest clear.
    function automatic logic ctl_rst_high(input int k);
        return (k == int'(CTL_GPIO)) || (k == int'(CTL_PU));
    endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        stage1 <= d;
        stage2 <= stage1;
    end

    assign q = stage2;
endmodule

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg #(
    parameter int           W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    assign set_m = set_en ? mask : '0;
    assign clr_m = clr_en ? mask : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= (q | set_m) & ~clr_m;
    end
endmodule

// File: rtl/pm_pad_drive.sv
module pm_pad_drive #(
    parameter int W = 32
) (
    input  logic [W-1:0] gpio_en,
    input  logic [W-1:0] sel_b,
    input  logic [W-1:0] oe,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] od,
    input  logic [W-1:0] pa_out,
    input  logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_out,
    input  logic [W-1:0] pb_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic src_o;
        logic src_e;
        assign src_o = gpio_en[i] ? dout[i] : (sel_b[i] ? pb_out[i] : pa_out[i]);
        assign src_e = gpio_en[i] ? oe[i]   : (sel_b[i] ? pb_oe[i]  : pa_oe[i]);
        // open-drain: never drive high, enable only to pull low
        assign pad_out[i] = src_o & ~od[i];
        assign pad_oe[i]  = src_e & ~(od[i] & src_o);
    end
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
    import pinmux_pkg::*;
#(
    parameter int NP = pinmux_pkg::NPIN,
    parameter int AW = pinmux_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [NP-1:0] bus_wdata,
    output logic [NP-1:0] bus_rdata,
    input  logic [NP-1:0] pad_in,
    output logic [NP-1:0] pad_out,
    output logic [NP-1:0] pad_oe,
    output logic [NP-1:0] pad_pu,
    input  logic [NP-1:0] pa_out,
    input  logic [NP-1:0] pa_oe,
    input  logic [NP-1:0] pb_out,
    input  logic [NP-1:0] pb_oe,
    output logic [NP-1:0] periph_in
);
    localparam int NC = pinmux_pkg::NCTL;

    addr_dec_t     dec;
    logic          wr_go;
    logic          rd_go;
    logic [NP-1:0] ctl_q [NC];
    logic [NP-1:0] level_s;
    logic [NP-1:0] rd_val;

    logic [NP-1:0] gpio_en_q, selb_q, oe_q, dout_q, pu_q, od_q;

    assign dec   = decode_addr(bus_addr);
    assign wr_go = bus_sel &&  bus_wr;
    assign rd_go = bus_sel && !bus_wr;

    for (genvar k = 0; k < NC; k++) begin : g_ctl
        localparam logic [NP-1:0] RV = ctl_rst_high(k) ? '1 : '0;
        logic s_en, c_en;
        assign s_en = wr_go && (dec.op == OP_SET) && (dec.idx == ctl_idx_e'(k));
        assign c_en = wr_go && (dec.op == OP_CLR) && (dec.idx == ctl_idx_e'(k));
        pm_ctl_reg #(.W(NP), .RST_VAL(RV)) u_reg (
            .clk    (clk),
            .rst    (rst),
            .set_en (s_en),
            .clr_en (c_en),
            .mask   (bus_wdata),
            .q      (ctl_q[k])
        );
    end

    assign gpio_en_q = ctl_q[CTL_GPIO];
    assign selb_q    = ctl_q[CTL_SELB];
    assign oe_q      = ctl_q[CTL_OE];
    assign dout_q    = ctl_q[CTL_DOUT];
    assign pu_q      = ctl_q[CTL_PU];
    assign od_q      = ctl_q[CTL_OD];

    pm_sync #(.W(NP)) u_sync (
        .clk (clk),
        .d   (pad_in),
        .q   (level_s)
    );

    pm_pad_drive #(.W(NP)) u_drive (
        .gpio_en (gpio_en_q),
        .sel_b   (selb_q),
        .oe      (oe_q),
        .dout    (dout_q),
        .od      (od_q),
        .pa_out  (pa_out),
        .pa_oe   (pa_oe),
        .pb_out  (pb_out),
        .pb_oe   (pb_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    always_comb begin
        rd_val = '0;
        if (dec.op == OP_STAT) begin
            case (dec.idx)
                CTL_GPIO:  rd_val = gpio_en_q;
                CTL_SELB:  rd_val = selb_q;
                CTL_OE:    rd_val = oe_q;
                CTL_DOUT:  rd_val = dout_q;
                CTL_PU:    rd_val = pu_q;
                CTL_OD:    rd_val = od_q;
                CTL_LEVEL: rd_val = level_s;
                default:   rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (rd_go) bus_rdata <= rd_val;
        else            bus_rdata <= '0;
    end

    assign pad_pu    = pu_q;
    assign periph_in = level_s;
endmodule

// File: rtl/pinmux_bank_chk.sv
module pinmux_bank_chk #(
    parameter int NP = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [NP-1:0] bus_wdata,
    input logic [NP-1:0] bus_rdata,
    input logic [NP-1:0] pad_in,
    input logic [NP-1:0] periph_in,
    input logic [NP-1:0] pad_out,
    input logic [NP-1:0] pad_oe,
    input logic [NP-1:0] pad_pu,
    input logic [NP-1:0] gpio_en_q,
    input logic [NP-1:0] oe_q,
    input logic [NP-1:0] dout_q,
    input logic [NP-1:0] pu_q,
    input logic [NP-1:0] od_q
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gpio_en_q == '1 && oe_q == '0 && pu_q == '1 &&
                        od_q == '0 && dout_q == '0));

    p_set_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 5'h08) |=>
            ((oe_q & $past(bus_wdata)) == $past(bus_wdata)) &&
            ((oe_q & ~$past(bus_wdata)) == ($past(oe_q) & ~$past(bus_wdata))));

    p_clr_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 5'h0D) |=>
            ((dout_q & $past(bus_wdata)) == '0) &&
            ((dout_q & ~$past(bus_wdata)) == ($past(dout_q) & ~$past(bus_wdata))));

    p_read_lat_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 5'h0A) |=> bus_rdata == $past(oe_q));

    p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> bus_rdata == '0);

    p_od_low_r7: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & od_q & pad_out) == '0);

    p_pu_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr[4:2] == 3'd4) |=> $stable(pad_pu));

    p_sync_r9: assert property (@(posedge clk) disable iff (rst)
        periph_in == $past(pad_in, 2));
endmodule

bind pinmux_bank pinmux_bank_chk #(.NP(NP), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .periph_in (periph_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .gpio_en_q (gpio_en_q),
    .oe_q      (oe_q),
    .dout_q    (dout_q),
    .pu_q      (pu_q),
    .od_q      (od_q)
);

// File: tb/test_pinmux_bank.sv
module test_pinmux_bank;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_OPS   = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pu, periph_in;
    logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinmux_bank i_pinmux_bank (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
        .periph_in(periph_in)
    );

    // reference model: 0 gpio,1 selb,2 oe,3 dout,4 pu,5 od
    logic [31:0] m [6];
    logic [31:0] lvl;
    int n_vec = 0;
    int n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_out();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            logic s;
            s = m[0][i] ? m[3][i] : (m[1][i] ? pb_out[i] : pa_out[i]);
            r[i] = s & ~m[5][i];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_oe();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            logic s, e;
            s = m[0][i] ? m[3][i] : (m[1][i] ? pb_out[i] : pa_out[i]);
            e = m[0][i] ? m[2][i] : (m[1][i] ? pb_oe[i]  : pa_oe[i]);
            r[i] = m[5][i] ? (e & ~s) : e;
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        if (a[1:0] == 2'd2 && a[4:2] < 3'd6) return m[a[4:2]];
        if (a == 5'h1A) return lvl;
        return '0;
    endfunction

    task automatic check_pads(input string req);
        check({req, " pad_out"}, pad_out, exp_out());
        check({req, " pad_oe"},  pad_oe,  exp_oe());
        check({req, " pad_pu"},  pad_pu,  m[4]);
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (a[4:2] < 3'd6) begin
            if (a[1:0] == 2'd0) m[a[4:2]] = m[a[4:2]] | d;
            if (a[1:0] == 2'd1) m[a[4:2]] = m[a[4:2]] & ~d;
        end
    endtask

    task automatic bus_read_chk(input string req, input logic [4:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog (all): actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m[0] = '1; m[1] = '0; m[2] = '0; m[3] = '0; m[4] = '1; m[5] = '0;
        lvl = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 rdata after reset", bus_rdata, 32'h0);
        for (int k = 0; k < 6; k++) bus_read_chk("R1 reset status", 5'(k * 4 + 2));
        check_pads("R1");

        // R2: set by mask
        bus_write(5'h08, 32'h0000_00F0);
        bus_write(5'h08, 32'h0F00_0000);
        bus_read_chk("R2 oe set mask", 5'h0A);
        bus_write(5'h0C, 32'hA5A5_00FF);
        bus_read_chk("R2 dout set mask", 5'h0E);
        check_pads("R5 gpio drive");

        // R3: clear by mask
        bus_write(5'h0D, 32'h0000_000F);
        bus_read_chk("R3 dout clear mask", 5'h0E);
        bus_write(5'h09, 32'h0000_0030);
        bus_read_chk("R3 oe clear mask", 5'h0A);
        check_pads("R5 gpio after clear");

        // R4: status/unmapped writes ignored, non-status reads zero
        bus_write(5'h0A, 32'hFFFF_FFFF);
        bus_write(5'h1F, 32'hFFFF_FFFF);
        bus_write(5'h03, 32'hFFFF_FFFF);
        bus_read_chk("R4 oe after status write", 5'h0A);
        bus_read_chk("R4 gpio after rsvd write", 5'h02);
        bus_read_chk("R4 read of set address", 5'h08);
        bus_read_chk("R4 read of unmapped", 5'h1F);

        // R6: peripheral mux
        pa_out = 32'h1234_5678; pa_oe = 32'hFF00_FF00;
        pb_out = 32'h8765_4321; pb_oe = 32'h0F0F_0F0F;
        bus_write(5'h01, 32'hFFFF_0000);
        bus_write(5'h04, 32'hF0F0_F0F0);
        check_pads("R6 mux A/B");
        bus_write(5'h05, 32'h3000_0000);
        check_pads("R6 back to A");

        // R7: open-drain on gpio and peripheral pins
        bus_write(5'h14, 32'hC3C3_C3C3);
        check_pads("R7 open-drain");
        bus_read_chk("R7 od status", 5'h16);

        // R8: pull-up
        bus_write(5'h11, 32'h00FF_FF00);
        check_pads("R8 pull-up clear");
        bus_write(5'h10, 32'h0000_0F00);
        check_pads("R8 pull-up set");

        // R9: two-edge synchronizer and pin-level read
        @(negedge clk);
        pad_in = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R9 one edge not yet", periph_in, 32'h0);
        @(negedge clk);
        check("R9 two edges", periph_in, 32'hDEAD_BEEF);
        lvl = 32'hDEAD_BEEF;
        bus_read_chk("R9 level read incl peripheral pins", 5'h1A);

        // random mix
        for (int it = 0; it < RAND_OPS; it++) begin
            logic [4:0]  a;
            logic [31:0] d;
            a = 5'($urandom_range(0, 31));
            d = $urandom();
            pa_out = $urandom(); pa_oe = $urandom();
            pb_out = $urandom(); pb_oe = $urandom();
            if (it % 16 == 0) begin
                pad_in = $urandom();
                @(negedge clk); @(negedge clk);
                lvl = pad_in;
            end
            if ($urandom_range(0, 1) == 0) bus_write(a, d);
            else                           bus_read_chk("R2 R3 R4 R9 random read", a);
            check_pads("R5 R6 R7 R8 random");
        end

        finish_run();
    end
endmodule